// File: doc/BRIEF.md
# Parallel Microprocessor Slave Port

This block turns an 8-bit device port into a byte mailbox that an external processor reaches through three active-low control inputs: chip select, read strobe and write strobe. The host drives these without any relation to the local clock. Inside the device, local logic talks to the block through single-cycle pulses on a synchronous interface. It loads an outbound byte, takes an inbound byte and clears the status flags.

While slave mode is off, the pins are a plain general-purpose port. A local latch drives them, a per-bit direction vector enables each output, and the sampled pin levels can be read back. Slave mode is valid only when the mode bit is set and all three control-pin direction bits are set to input. In that mode the control pins pass through two-flop synchronizers. A write transfer starts when chip select and write strobe are first seen low together. It completes when either returns high, and the byte is then copied into the input buffer. A read transfer completes when chip select or read strobe returns high. Each completed transfer raises the interrupt flag. The pad drivers carry the output buffer only while chip select and read strobe are both low.

Top module: `pmp_slave_port`

## Requirements
- R1: With slave mode off, `pad_o` equals the general-purpose latch last written by `port_wr`, and `pad_oe` equals `port_dir` (1 = drive). Strobes then cause no transfer and change no flag.
- R2: When `slave_en` is 1 but any bit of `ctl_dir_in` is 0 (0 = configured as output), slave mode is invalid. The port behaves as in R1 and no transfer happens.
- R3: An external write (chip select and write strobe both low, then either returning high) copies the byte held on `pad_i` during the strobe into the input buffer (`ibuf_rdata`) and sets `ibf`.
- R4: A one-cycle `ibuf_rd` pulse clears `ibf`. `ibuf_rdata` keeps the byte.
- R5: An external write that starts while `ibf` is 1 sets `ovf`, and the new byte replaces the old one. `ovf` stays at 1 until an `ovf_clr` pulse.
- R6: An `obuf_wr` pulse loads `obuf_wdata` into the output buffer and sets `obf`. A completed external read clears `obf`.
- R7: In valid slave mode, `pad_oe` is all ones and `pad_o` equals the output buffer exactly while `host_cs_n` and `host_rd_n` are both 0. At all other times in slave mode `pad_oe` is all zeros.
- R8: Each completed external read or write sets `irq`. `irq` stays at 1 until an `irq_clr` pulse.
- R9: Read or write strobes asserted while `host_cs_n` is 1 start no transfer.
- R10: After reset, `ibf`, `obf`, `ovf` and `irq` are 0, and `pad_oe` is 0 when `port_dir` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_en | input | 1 | Slave mode control bit |
| ctl_dir_in | input | 3 | Direction bits of the three control pins, 1 = input |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| pad_i | input | DATA_W | Levels seen on the data pins |
| pad_o | output | DATA_W | Value driven to the data pins |
| pad_oe | output | DATA_W | Per-pin output enable |
| port_wr | input | 1 | Load the general-purpose latch |
| port_wdata | input | DATA_W | Data for the general-purpose latch |
| port_dir | input | DATA_W | General-purpose direction, 1 = drive |
| port_pins | output | DATA_W | Synchronized pin levels |
| obuf_wr | input | 1 | Load the output buffer |
| obuf_wdata | input | DATA_W | Byte for the output buffer |
| ibuf_rd | input | 1 | Local read of the input buffer |
| ibuf_rdata | output | DATA_W | Input buffer contents |
| ibf | output | 1 | Input buffer full |
| obf | output | 1 | Output buffer full |
| ovf | output | 1 | Sticky input overflow |
| ovf_clr | input | 1 | Clear `ovf` |
| irq | output | 1 | Transfer interrupt flag |
| irq_clr | input | 1 | Clear `irq` |

## Verification
The assertions assume that host strobes are held for several local clock cycles. They also assume that data on `pad_i` is stable for the whole time chip select and write strobe are both low, and that local pulses last one cycle. The stimulus meets these assumptions in every case. Each host strobe lasts four cycles, and the bench waits several cycles between transfers. Write data changes only after the strobe has been released. Random sequences of host writes, host reads, local loads, local reads and flag clears run against a bench model. Directed cases cover general-purpose mode, invalid direction settings, strobes without chip select, and overflow.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  typedef struct packed {
    logic wr_start;
    logic wr_done;
    logic rd_done;
    logic wr_active;
  } pmp_evt_t;

  localparam int unsigned CTL_PINS = 3;
endpackage

// File: rtl/pmp_sync.sv
module pmp_sync #(
  parameter int unsigned WIDTH     = 1,
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= {WIDTH{RESET_VAL}};
      else if (s == 0) stage_q[s] <= d_async;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pmp_xfer_detect.sv
module pmp_xfer_detect
  import pmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     valid,
  input  logic     cs_s_n,
  input  logic     rd_s_n,
  input  logic     wr_s_n,
  output pmp_evt_t evt
);
  logic wr_act, rd_act, wr_prev, rd_prev;

  assign wr_act = valid & ~cs_s_n & ~wr_s_n;
  assign rd_act = valid & ~cs_s_n & ~rd_s_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      wr_prev <= wr_act;
      rd_prev <= rd_act;
    end
  end

  always_comb begin
    evt.wr_start  = wr_act & ~wr_prev;
    evt.wr_done   = valid & wr_prev & ~wr_act;
    evt.rd_done   = valid & rd_prev & ~rd_act;
    evt.wr_active = wr_act;
  end

  // R9: a chip select held high never yields a write start
  assert_no_start_without_cs_R9: assert property (@(posedge clk) disable iff (rst)
    cs_s_n |-> !evt.wr_start);
endmodule

// File: rtl/pmp_flags.sv
module pmp_flags
  import pmp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pmp_evt_t          evt,
  input  logic [DATA_W-1:0] host_data_s,
  input  logic              obuf_wr,
  input  logic [DATA_W-1:0] obuf_wdata,
  input  logic              ibuf_rd,
  input  logic              ovf_clr,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] ibuf_q,
  output logic [DATA_W-1:0] obuf_q,
  output logic              ibf,
  output logic              obf,
  output logic              ovf,
  output logic              irq
);
  logic [DATA_W-1:0] stage_q;

  // staging keeps the last byte seen while the write condition held
  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else if (evt.wr_active) stage_q <= host_data_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ibuf_q <= '0;
      ibf    <= 1'b0;
    end else if (evt.wr_done) begin
      ibuf_q <= stage_q;
      ibf    <= 1'b1;
    end else if (ibuf_rd) begin
      ibf    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obuf_q <= '0;
      obf    <= 1'b0;
    end else if (obuf_wr) begin
      obuf_q <= obuf_wdata;
      obf    <= 1'b1;
    end else if (evt.rd_done) begin
      obf    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else if (evt.wr_start && ibf) ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else if (evt.wr_done || evt.rd_done) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  assert_ibf_after_write_R3: assert property (@(posedge clk) disable iff (rst)
    evt.wr_done |=> ibf);
  assert_ibf_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    (ibuf_rd && !evt.wr_done) |=> !ibf);
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);
  assert_obf_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    (evt.rd_done && !obuf_wr) |=> !obf);
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/pmp_slave_port.sv
module pmp_slave_port
  import pmp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slave_en,
  input  logic [CTL_PINS-1:0] ctl_dir_in,
  input  logic                host_cs_n,
  input  logic                host_rd_n,
  input  logic                host_wr_n,
  input  logic [DATA_W-1:0]   pad_i,
  output logic [DATA_W-1:0]   pad_o,
  output logic [DATA_W-1:0]   pad_oe,
  input  logic                port_wr,
  input  logic [DATA_W-1:0]   port_wdata,
  input  logic [DATA_W-1:0]   port_dir,
  output logic [DATA_W-1:0]   port_pins,
  input  logic                obuf_wr,
  input  logic [DATA_W-1:0]   obuf_wdata,
  input  logic                ibuf_rd,
  output logic [DATA_W-1:0]   ibuf_rdata,
  output logic                ibf,
  output logic                obf,
  output logic                ovf,
  input  logic                ovf_clr,
  output logic                irq,
  input  logic                irq_clr
);
  logic              slave_valid;
  logic [2:0]        ctl_s;
  logic [DATA_W-1:0] data_s;
  logic [DATA_W-1:0] gpio_q;
  logic [DATA_W-1:0] obuf_q;
  logic              host_read_now;
  pmp_evt_t          evt;

  assign slave_valid = slave_en & (&ctl_dir_in);

  pmp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ctl_sync (
    .clk(clk), .rst(rst),
    .d_async({host_cs_n, host_rd_n, host_wr_n}),
    .q_sync(ctl_s)
  );

  pmp_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_data_sync (
    .clk(clk), .rst(rst),
    .d_async(pad_i),
    .q_sync(data_s)
  );

  pmp_xfer_detect u_detect (
    .clk(clk), .rst(rst), .valid(slave_valid),
    .cs_s_n(ctl_s[2]), .rd_s_n(ctl_s[1]), .wr_s_n(ctl_s[0]),
    .evt(evt)
  );

  pmp_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .evt(evt), .host_data_s(data_s),
    .obuf_wr(obuf_wr), .obuf_wdata(obuf_wdata), .ibuf_rd(ibuf_rd),
    .ovf_clr(ovf_clr), .irq_clr(irq_clr),
    .ibuf_q(ibuf_rdata), .obuf_q(obuf_q),
    .ibf(ibf), .obf(obf), .ovf(ovf), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) gpio_q <= '0;
    else if (port_wr) gpio_q <= port_wdata;
  end

  assign port_pins     = data_s;
  assign host_read_now = slave_valid & ~host_cs_n & ~host_rd_n;

  // pad path follows the host strobes directly, as an external bus requires
  always_comb begin
    if (slave_valid) begin
      pad_o  = obuf_q;
      pad_oe = {DATA_W{host_read_now}};
    end else begin
      pad_o  = gpio_q;
      pad_oe = port_dir;
    end
  end

  // R1 and R2: without valid slave mode no transfer can raise the interrupt
  assert_no_xfer_when_invalid_R2: assert property (@(posedge clk) disable iff (rst)
    (!slave_valid && !$past(slave_valid)) |-> !$rose(irq));
endmodule

// File: tb/tb_pmp_slave_port.sv
module tb_pmp_slave_port;
  localparam int W = 8;
  logic clk = 0, rst = 1;
  logic slave_en = 0;
  logic [2:0] ctl_dir_in = 3'b111;
  logic host_cs_n = 1, host_rd_n = 1, host_wr_n = 1;
  logic [W-1:0] pad_i = '0, pad_o, pad_oe;
  logic port_wr = 0; logic [W-1:0] port_wdata = '0, port_dir = '0, port_pins;
  logic obuf_wr = 0; logic [W-1:0] obuf_wdata = '0;
  logic ibuf_rd = 0; logic [W-1:0] ibuf_rdata;
  logic ibf, obf, ovf, irq, ovf_clr = 0, irq_clr = 0;

  int n_chk = 0, n_fail = 0;
  logic m_ibf = 0, m_obf = 0, m_ovf = 0, m_irq = 0;
  logic [W-1:0] m_ibuf = '0, m_obuf = '0;

  always #2 clk = ~clk;

  pmp_slave_port #(.DATA_W(W)) dut (
    .clk, .rst, .slave_en, .ctl_dir_in, .host_cs_n, .host_rd_n, .host_wr_n,
    .pad_i, .pad_o, .pad_oe, .port_wr, .port_wdata, .port_dir, .port_pins,
    .obuf_wr, .obuf_wdata, .ibuf_rd, .ibuf_rdata, .ibf, .obf, .ovf, .ovf_clr,
    .irq, .irq_clr);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] flags_exp();
    return {m_ibf, m_obf, m_ovf, m_irq};
  endfunction

  task automatic check_flags(string req);
    check(req, {ibf, obf, ovf, irq}, flags_exp());
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(logic [W-1:0] d, logic use_cs, logic model);
    @(negedge clk);
    pad_i = d; host_cs_n = !use_cs; host_wr_n = 0;
    cycles(4);
    host_wr_n = 1; host_cs_n = 1;
    cycles(1);
    pad_i = ~d;
    cycles(5);
    if (model) begin
      if (m_ibf) m_ovf = 1;
      m_ibuf = d; m_ibf = 1; m_irq = 1;
    end
  endtask

  task automatic host_read(logic model);
    @(negedge clk);
    host_cs_n = 0; host_rd_n = 0;
    cycles(2);
    if (model) begin
      check("R7 oe", pad_oe, {W{1'b1}});
      check("R7 data", pad_o, m_obuf);
    end
    cycles(2);
    host_rd_n = 1; host_cs_n = 1;
    #1;
    if (model) check("R7 release", pad_oe, '0);
    cycles(5);
    if (model) begin m_obf = 0; m_irq = 1; end
  endtask

  task automatic pulse_obuf(logic [W-1:0] d);
    @(negedge clk); obuf_wr = 1; obuf_wdata = d;
    @(negedge clk); obuf_wr = 0;
    m_obuf = d; m_obf = 1;
  endtask

  task automatic pulse_ibuf_rd();
    check("R3 ibuf data", ibuf_rdata, m_ibuf);
    @(negedge clk); ibuf_rd = 1;
    @(negedge clk); ibuf_rd = 0;
    m_ibf = 0;
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    m_irq = 0;
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    m_ovf = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    cycles(3);
    rst = 0;
    cycles(1);
    // R10 reset state
    check_flags("R10 flags");
    check("R10 oe", pad_oe, '0);

    // R1 general-purpose mode
    @(negedge clk); port_wr = 1; port_wdata = 8'hA5; port_dir = 8'h0F;
    @(negedge clk); port_wr = 0;
    #1;
    check("R1 pad_o", pad_o, 8'hA5);
    check("R1 pad_oe", pad_oe, 8'h0F);
    host_write(8'h33, 1, 0);
    check_flags("R1 no transfer");
    port_dir = '0;

    // R2 invalid direction settings
    slave_en = 1; ctl_dir_in = 3'b101;
    host_write(8'h44, 1, 0);
    host_read(0);
    check_flags("R2 no transfer");
    check("R2 gpio output", pad_o, 8'hA5);
    ctl_dir_in = 3'b111;
    cycles(2);

    // R9 strobe without chip select
    host_write(8'h55, 0, 0);
    check_flags("R9 no write");
    @(negedge clk); host_rd_n = 0;
    cycles(3);
    check("R9 no drive", pad_oe, '0);
    host_rd_n = 1;
    cycles(4);
    check_flags("R9 no read");

    // R3 R8 write, R4 local read, R5 overflow
    host_write(8'h5A, 1, 1);
    check_flags("R3 R8 write");
    host_write(8'hC3, 1, 1);
    check_flags("R5 overflow set");
    check("R5 overwrite", ibuf_rdata, 8'hC3);
    pulse_ibuf_rd();
    cycles(1);
    check_flags("R4 ibf clear");
    pulse_irq_clr();
    cycles(1);
    check_flags("R8 irq clear");
    pulse_ovf_clr();
    cycles(1);
    check_flags("R5 ovf clear");

    // R6 R7 output path
    pulse_obuf(8'h96);
    cycles(1);
    check_flags("R6 obf set");
    host_read(1);
    check_flags("R6 obf clear");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: host_write(W'($urandom), 1, 1);
        1: host_read(1);
        2: pulse_obuf(W'($urandom));
        3: pulse_ibuf_rd();
        4: pulse_irq_clr();
        default: pulse_ovf_clr();
      endcase
      cycles(1);
      check_flags("R3 R4 R5 R6 R8 random");
    end
    finish_run();
  end
endmodule